// File: doc/BRIEF.md
# I2C Controller Event Flags and Interrupt Vector

This block keeps the sticky event flags of an I2C master controller and turns them into one CPU interrupt line and two DMA request lines. The transfer engine beside it sends single-cycle event pulses on a 16-bit vector. Each pulse on a defined flag position sets the matching flag, and the flag stays set until software takes it.

Software reaches the block over a small 16-bit register bus. A write selects a register with `regSel` and `regWr`. A read returns data combinationally in the cycle in which `regRd` is high. A plain status read has no side effect. A vector read returns a code for the lowest-numbered pending enabled event and clears that flag at the end of the same access. Turning on a DMA direction also clears the interrupt-enable bit for that direction, so the interrupt does not compete with the DMA request.

The register select codes are: 0 identification (read-only), 1 interrupt mask, 2 status (read-only), 3 vector (read-only), 5 DMA control. Any other code reads as zero and ignores writes.

Top module: `i2c_evt_irq`

## Requirements
- R1: A synchronous `rst` clears the mask, the status flags and both DMA enables, and so does a cycle with `modDisable` high. After either, the status, mask and DMA reads all return 0.
- R2: An `evtPulse` bit sets the status flag at the same bit position. Only these positions are stored: 1 (no-acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun) and 15 (single byte). A pulse on any other position is dropped. A stored flag stays set after its pulse ends.
- R3: A mask write (select 1) keeps only data bits 4..0. The mask reads back zero-extended.
- R4: `irq` is high exactly when (status bits 4..0) AND (mask) is non-zero. Mask bit k enables status bit k.
- R5: A vector read (select 3) returns k+1, where k is the lowest set bit of (status AND mask), or returns 0 when none is set. Status bit k is cleared at the clock edge that ends that read.
- R6: When an event pulse and a vector-read clear hit the same flag in the same cycle, the flag ends up set.
- R7: A status read (select 2) returns the stored flags, with bit 12 equal to the live `busBusy` input. Bit 12 is never stored.
- R8: A DMA control write (select 5) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable).
- R9: `rxDmaReq` equals status bit 3 while receive DMA is enabled and is 0 otherwise. `txDmaReq` equals status bit 4 while transmit DMA is enabled and is 0 otherwise.
- R10: A DMA control write with data bit 15 set clears mask bit 3. One with data bit 7 set clears mask bit 4. The other mask bits are kept.
- R11: Writes to the identification, status and vector selects change no state. The identification register reads 0x0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modDisable | input | 1 | Synchronous clear of the mask, the flags and the DMA enables |
| regSel | input | 3 | Register select code |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (the vector read has a side effect) |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid while regRd is high, 0 otherwise |
| evtPulse | input | 16 | Event pulses from the transfer engine, one bit per flag position |
| busBusy | input | 1 | Live bus-busy state, shown as status bit 12 |
| irq | output | 1 | CPU interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is a vector read that clears a flag in the same cycle in which the engine pulses that same flag. The bench holds `regRd` on the vector select and raises the matching `evtPulse` bit within one cycle. It then checks that the code returned was the one for that flag, and that a later status read and `irq` still show the flag. The ordering of the vector encoder is tested by loading several enabled flags together and draining them one vector read at a time. Masked pending flags are loaded alongside, to show they are passed over.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int MASK_W = 5;
  localparam int CODE_W = $clog2(MASK_W + 1);

  // Flag positions that are stored; everything else is dropped.
  localparam logic [DATA_W-1:0] FLAG_KEEP = 16'h8E1E;
  localparam int BUSY_BIT   = 12;
  localparam int RX_RDY_BIT = 3;
  localparam int TX_RDY_BIT = 4;
  localparam int RX_DMA_BIT = 15;
  localparam int TX_DMA_BIT = 7;

  localparam logic [ADDR_W-1:0] SEL_CODE_ID   = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_CODE_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_CODE_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_CODE_VEC  = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_CODE_DMA  = 3'd5;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ID,
    RD_MASK,
    RD_STAT,
    RD_VEC,
    RD_DMA
  } rdSrc_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrDma;
    logic   rdVec;
    rdSrc_e rdSrc;
  } evtStrobe_t;

endpackage

// File: rtl/i2c_evt_prio_enc.sv
module i2c_evt_prio_enc #(
  parameter int W = 5,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  grant,
  output logic [CW-1:0] code
);

  // Lowest index wins; code is the 1-based index, 0 when idle.
  always_comb begin
    grant = '0;
    code  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        code  = CW'(i + 1);
      end
    end
  end

endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
(
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  output evtStrobe_t        strb
);

  always_comb begin
    strb.wrMask = regWr && (regSel == SEL_CODE_MASK);
    strb.wrDma  = regWr && (regSel == SEL_CODE_DMA);
    strb.rdVec  = regRd && (regSel == SEL_CODE_VEC);
    strb.rdSrc  = RD_NONE;
    if (regRd) begin
      unique case (regSel)
        SEL_CODE_ID:   strb.rdSrc = RD_ID;
        SEL_CODE_MASK: strb.rdSrc = RD_MASK;
        SEL_CODE_STAT: strb.rdSrc = RD_STAT;
        SEL_CODE_VEC:  strb.rdSrc = RD_VEC;
        SEL_CODE_DMA:  strb.rdSrc = RD_DMA;
        default:       strb.rdSrc = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_evt_datapath.sv
module i2c_evt_datapath
  import i2c_evt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 16'h0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modDisable,
  input  evtStrobe_t        strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] evtPulse,
  input  logic              busBusy,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  logic [DATA_W-1:0] statQ, statD, clrVec, setVec;
  logic [MASK_W-1:0] maskQ, maskD, pend, grant;
  logic [CODE_W-1:0] vecCode;
  logic              rxDmaEnQ, txDmaEnQ;

  assign pend = statQ[MASK_W-1:0] & maskQ;
  assign irq  = |pend;

  i2c_evt_prio_enc #(.W(MASK_W)) u_enc (
    .req  (pend),
    .grant(grant),
    .code (vecCode)
  );

  assign clrVec = strb.rdVec ? DATA_W'(grant) : '0;
  assign setVec = evtPulse & FLAG_KEEP;
  assign statD  = (statQ & ~clrVec) | setVec;

  always_comb begin
    maskD = maskQ;
    if (strb.wrMask) begin
      maskD = regWdata[MASK_W-1:0];
    end else if (strb.wrDma) begin
      if (regWdata[RX_DMA_BIT]) maskD[RX_RDY_BIT] = 1'b0;
      if (regWdata[TX_DMA_BIT]) maskD[TX_RDY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || modDisable) begin
      statQ    <= '0;
      maskQ    <= '0;
      rxDmaEnQ <= 1'b0;
      txDmaEnQ <= 1'b0;
    end else begin
      statQ <= statD;
      maskQ <= maskD;
      if (strb.wrDma) begin
        rxDmaEnQ <= regWdata[RX_DMA_BIT];
        txDmaEnQ <= regWdata[TX_DMA_BIT];
      end
    end
  end

  assign rxDmaReq = rxDmaEnQ && statQ[RX_RDY_BIT];
  assign txDmaReq = txDmaEnQ && statQ[TX_RDY_BIT];

  always_comb begin
    regRdata = '0;
    unique case (strb.rdSrc)
      RD_ID:   regRdata = ID_VALUE;
      RD_MASK: regRdata = DATA_W'(maskQ);
      RD_STAT: begin
        regRdata = statQ;
        regRdata[BUSY_BIT] = busBusy;
      end
      RD_VEC:  regRdata = DATA_W'(vecCode);
      RD_DMA: begin
        regRdata[RX_DMA_BIT] = rxDmaEnQ;
        regRdata[TX_DMA_BIT] = txDmaEnQ;
      end
      default: regRdata = '0;
    endcase
  end

  // R1: disable leaves every held register cleared
  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (rst)
    modDisable |=> (statQ == '0 && maskQ == '0 && !rxDmaEnQ && !txDmaEnQ));

  // R2 and R6: a pulse on a kept position is always visible next cycle
  assert_pulse_sticks_R6: assert property (@(posedge clk) disable iff (rst)
    !modDisable |=> ((statQ & $past(evtPulse & FLAG_KEEP)) == $past(evtPulse & FLAG_KEEP)));

  // R5: the reported flag is gone after the vector read unless re-pulsed
  assert_vec_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.rdVec && (pend != '0) && !modDisable &&
     ((evtPulse[MASK_W-1:0] & grant) == '0))
    |=> ((statQ[MASK_W-1:0] & $past(grant)) == '0));

  // R3: mask write keeps the low data bits
  assert_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.wrMask && !modDisable) |=> (maskQ == $past(regWdata[MASK_W-1:0])));

  // R10: enabling receive DMA drops the receive-ready interrupt enable
  assert_rxdma_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (strb.wrDma && regWdata[RX_DMA_BIT]) |=> !maskQ[RX_RDY_BIT]);

  // R7: the busy position is never held in the flag register
  assert_busy_unstored_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !statQ[BUSY_BIT]);

endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_evt_pkg::*;
#(
  parameter logic [15:0] ID_VALUE = 16'h0011
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        modDisable,
  input  logic [2:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic [15:0] evtPulse,
  input  logic        busBusy,
  output logic        irq,
  output logic        rxDmaReq,
  output logic        txDmaReq
);

  evtStrobe_t strb;

  i2c_evt_ctrl u_ctrl (
    .regSel(regSel),
    .regWr (regWr),
    .regRd (regRd),
    .strb  (strb)
  );

  i2c_evt_datapath #(.ID_VALUE(ID_VALUE)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .modDisable(modDisable),
    .strb      (strb),
    .regWdata  (regWdata),
    .evtPulse  (evtPulse),
    .busBusy   (busBusy),
    .regRdata  (regRdata),
    .irq       (irq),
    .rxDmaReq  (rxDmaReq),
    .txDmaReq  (txDmaReq)
  );

endmodule

// File: tb/sim_i2c_evt_irq.sv
module sim_i2c_evt_irq;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_ID = 3'd0, S_MASK = 3'd1, S_STAT = 3'd2, S_VEC = 3'd3, S_DMA = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modDisable = 1'b0;
  logic [2:0] regSel = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [15:0] regWdata = '0, regRdata;
  logic [15:0] evtPulse = '0;
  logic busBusy = 1'b0;
  logic irq, rxDmaReq, txDmaReq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_evt_irq u0 (
    .clk(clk), .rst(rst), .modDisable(modDisable), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .evtPulse(evtPulse), .busBusy(busBusy), .irq(irq),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%04h exp=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    regSel = sel; regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] data);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 data = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk);
    evtPulse = bits;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic disable_clear();
    @(negedge clk);
    modDisable = 1'b1;
    @(negedge clk);
    modDisable = 1'b0;
  endtask

  function automatic logic [15:0] exp_vec(input logic [15:0] stat, input logic [4:0] mask);
    logic [4:0] p = stat[4:0] & mask;
    for (int i = 0; i < 5; i++) if (p[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    rd(S_MASK, d); chk("R1 reset mask", d, 16'h0000);
    rd(S_STAT, d); chk("R1 reset stat", d, 16'h0000);
    rd(S_DMA, d);  chk("R1 reset dma", d, 16'h0000);
    chk("R1 reset irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    pulse(16'hFFFF);
    rd(S_STAT, d); chk("R2 kept positions", d, 16'h8E1E);
    repeat (3) @(negedge clk);
    rd(S_STAT, d); chk("R2 sticky", d, 16'h8E1E);
    disable_clear();
    pulse(16'h71E1);
    rd(S_STAT, d); chk("R2 unkept dropped", d, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(S_MASK, 16'hFFFF);
    rd(S_MASK, d); chk("R3 mask width", d, 16'h001F);
    wr(S_MASK, 16'hFFEA);
    rd(S_MASK, d); chk("R3 mask pattern", d, 16'h000A);
    wr(S_MASK, 16'h0000);
  endtask

  task automatic t_irq();
    pulse(16'h0008);
    @(negedge clk); chk("R4 masked no irq", {15'b0, irq}, 16'h0000);
    wr(S_MASK, 16'h0008);
    @(negedge clk); chk("R4 enabled irq", {15'b0, irq}, 16'h0001);
    wr(S_MASK, 16'h0010);
    @(negedge clk); chk("R4 other bit no irq", {15'b0, irq}, 16'h0000);
    disable_clear();
  endtask

  task automatic t_vector();
    logic [15:0] d;
    wr(S_MASK, 16'h001F);
    pulse(16'h8216);
    rd(S_VEC, d); chk("R5 first code", d, exp_vec(16'h0016, 5'h1F));
    rd(S_STAT, d); chk("R5 bit1 cleared", d, 16'h8214);
    rd(S_VEC, d); chk("R5 second code", d, 16'd3);
    rd(S_VEC, d); chk("R5 third code", d, 16'd5);
    rd(S_VEC, d); chk("R5 empty code", d, 16'd0);
    rd(S_STAT, d); chk("R5 high flags kept", d, 16'h8200);
    chk("R5 irq low", {15'b0, irq}, 16'h0000);
    disable_clear();
    wr(S_MASK, 16'h001C);
    pulse(16'h0006);
    rd(S_VEC, d); chk("R5 masked skipped", d, 16'd3);
    rd(S_STAT, d); chk("R5 masked kept", d, 16'h0002);
    disable_clear();
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    wr(S_MASK, 16'h0004);
    pulse(16'h0004);
    @(negedge clk);
    regSel = S_VEC; regRd = 1'b1; evtPulse = 16'h0004;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0; evtPulse = '0;
    chk("R6 code in collision", d, 16'd3);
    chk("R6 irq stays", {15'b0, irq}, 16'h0001);
    rd(S_STAT, d); chk("R6 flag survives", d, 16'h0004);
    disable_clear();
  endtask

  task automatic t_busy();
    logic [15:0] d;
    pulse(16'h0400);
    busBusy = 1'b1;
    rd(S_STAT, d); chk("R7 busy shown", d, 16'h1400);
    busBusy = 1'b0;
    rd(S_STAT, d); chk("R7 busy live", d, 16'h0400);
    disable_clear();
  endtask

  task automatic t_dma();
    logic [15:0] d;
    wr(S_DMA, 16'hFFFF);
    rd(S_DMA, d); chk("R8 dma kept bits", d, 16'h8080);
    wr(S_DMA, 16'h7F7F);
    rd(S_DMA, d); chk("R8 dma others", d, 16'h0000);
    pulse(16'h0018);
    @(negedge clk); chk("R9 off", {14'b0, rxDmaReq, txDmaReq}, 16'h0000);
    wr(S_DMA, 16'h8000);
    @(negedge clk); chk("R9 rx only", {14'b0, rxDmaReq, txDmaReq}, 16'h0002);
    wr(S_DMA, 16'h0080);
    @(negedge clk); chk("R9 tx only", {14'b0, rxDmaReq, txDmaReq}, 16'h0001);
    wr(S_MASK, 16'h001F);
    wr(S_DMA, 16'h8000);
    rd(S_MASK, d); chk("R10 rx clears bit3", d, 16'h0017);
    wr(S_MASK, 16'h001F);
    wr(S_DMA, 16'h0080);
    rd(S_MASK, d); chk("R10 tx clears bit4", d, 16'h000F);
    wr(S_MASK, 16'h001F);
    wr(S_DMA, 16'h0000);
    rd(S_MASK, d); chk("R10 no enable keeps", d, 16'h001F);
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    disable_clear();
    wr(S_MASK, 16'h0006);
    rd(S_ID, d); chk("R11 id value", d, 16'h0011);
    wr(S_STAT, 16'hFFFF);
    wr(S_VEC, 16'hFFFF);
    wr(S_ID, 16'h0000);
    rd(S_STAT, d); chk("R11 stat unchanged", d, 16'h0000);
    rd(S_MASK, d); chk("R11 mask unchanged", d, 16'h0006);
    rd(S_ID, d); chk("R11 id unchanged", d, 16'h0011);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    wr(S_MASK, 16'h001F);
    wr(S_DMA, 16'h8080);
    pulse(16'h0E1E);
    disable_clear();
    rd(S_STAT, d); chk("R1 disable stat", d, 16'h0000);
    rd(S_MASK, d); chk("R1 disable mask", d, 16'h0000);
    rd(S_DMA, d);  chk("R1 disable dma", d, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_flags();
    t_mask();
    t_irq();
    t_vector();
    t_set_wins();
    t_busy();
    t_dma();
    t_readonly();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule